// File: doc/BRIEF.md
# Low-Power Stop Broadcast Handler

This block sits on a processor's internal bus and watches for the special write the processor issues when it enters low-power stop. That write goes to CPU space (function code 3'b111) at address 0x3FFFE. The block recognises the write and latches the 3-bit interrupt priority mask carried in it. It ends the cycle itself with a fast acknowledge, so no external device has to answer.

The cycle is shown on the external bus only while this master owns the bus. A bus error raised during the cycle has no effect. When the cycle completes, the block raises a stop request that the clock-gating logic uses to shut down system clocks. The request drops when a pending interrupt has a priority above the latched mask. An interrupt at the top level (7) also drops it, whatever the mask.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `lpstop_bcast_ctl`

## Requirements
- R1: A cycle counts as a stop broadcast only when all of these hold: the strobe `bus_as` is high, `bus_wr` is high, `bus_fc` equals 3'b111 and `bus_addr` equals 24'h03FFFE. Any other combination produces no acknowledge, leaves `stop_mask` unchanged and raises no stop request.
- R2: On a broadcast, `stop_mask` takes `bus_wdata[10:8]` at the clock edge that samples the broadcast. The value is visible in the acknowledge cycle. The other data bits are ignored.
- R3: `cyc_ack` is high for exactly one clock cycle, the cycle right after the edge that samples the broadcast. A single strobe assertion gives only one acknowledge, even when the strobe is held high afterwards.
- R4: `bus_err` has no effect. A broadcast with `bus_err` high gives the same acknowledge, mask and stop request as one without it.
- R5: `ext_show_en` is high together with `cyc_ack` only if `bus_owned` was high at the sampling edge. Otherwise it stays low.
- R6: `stop_req` rises in the cycle that follows the acknowledge cycle. It stays high while `irq_level` is not above `stop_mask` and is below 7.
- R7: While `stop_req` is high, an `irq_level` above `stop_mask` clears it at the next clock edge.
- R8: An `irq_level` of 7 clears `stop_req` even when `stop_mask` is 7.
- R9: During reset, `cyc_ack`, `ext_show_en` and `stop_req` are 0 and `stop_mask` is 3'b000.
- R10: If the wake condition already holds when the acknowledge cycle ends, `stop_req` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Internal bus address |
| bus_fc | input | 3 | Function code of the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_as | input | 1 | Address strobe, active high |
| bus_wr | input | 1 | High for a write cycle |
| bus_owned | input | 1 | High while this master holds the external bus |
| bus_err | input | 1 | Bus error indication (ignored for the broadcast) |
| irq_level | input | 3 | Priority of the highest pending interrupt, 0 = none |
| cyc_ack | output | 1 | Internal fast acknowledge for the broadcast |
| ext_show_en | output | 1 | Enables showing the cycle on the external bus |
| stop_mask | output | 3 | Latched interrupt priority mask |
| stop_req | output | 1 | Request to gate system clocks |

## Verification
The hardest situations to reach from the ports are those where two events land on the same clock edge.

- A wake-level interrupt is already pending at the moment the broadcast completes. The stimulus raises `irq_level` above the incoming mask before the broadcast is issued, so clear and set collide on one edge.
- The strobe is held high for several cycles after the acknowledge. This checks that the block does not decode the same cycle twice.
- A bus error arrives together with a broadcast while the bus is not owned.
- A second broadcast arrives while the stop request is already high. This shows that the mask is replaced and the request is kept.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_DRAIN = 2'd2
  } bcast_state_e;

endpackage

// File: rtl/lpstop_rst_sync.sv
module lpstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpstop_decode.sv
module lpstop_decode #(
  parameter int               ADDR_W     = 24,
  parameter int               FC_W       = 3,
  parameter logic [ADDR_W-1:0] MATCH_ADDR = 24'h03FFFE,
  parameter logic [FC_W-1:0]  MATCH_FC   = 3'b111
) (
  input  logic              bus_as,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FC_W-1:0]   bus_fc,
  output logic              hit
);

  logic space_ok;
  logic addr_ok;

  always_comb begin
    space_ok = (bus_fc == MATCH_FC);
    addr_ok  = (bus_addr == MATCH_ADDR);
    hit      = bus_as && bus_wr && space_ok && addr_ok;
  end

endmodule

// File: rtl/lpstop_seq.sv
module lpstop_seq
  import lpstop_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MASK_W   = 3,
  parameter int MASK_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              bus_as,
  input  logic              bus_owned,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              cyc_ack,
  output logic              ext_show_en,
  output logic [MASK_W-1:0] stop_mask,
  output logic              done_pulse
);

  bcast_state_e      state_q, state_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              show_q, show_d;

  // next state
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    show_d  = show_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hit) begin
          state_d = ST_ACK;
          mask_d  = bus_wdata[MASK_LSB +: MASK_W];
          show_d  = bus_owned;
        end
      end
      ST_ACK: begin
        show_d  = 1'b0;
        state_d = bus_as ? ST_DRAIN : ST_IDLE;
      end
      ST_DRAIN: begin
        if (!bus_as) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        show_d  = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      show_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      show_q  <= show_d;
    end
  end

  assign cyc_ack     = (state_q == ST_ACK);
  assign ext_show_en = show_q;
  assign stop_mask   = mask_q;
  assign done_pulse  = (state_q == ST_ACK);

  // R3: acknowledge lasts a single cycle
  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack |=> !cyc_ack);

  // R5: external show only accompanies the acknowledge
  a_r5_show_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ext_show_en |-> cyc_ack);

  // R4: a bus error together with the broadcast does not block the acknowledge
  a_r4_berr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hit && bus_err) |=> cyc_ack);

  // R2: mask only changes when a broadcast is taken
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == ST_IDLE && hit) |=> $stable(stop_mask));

endmodule

// File: rtl/lpstop_wake.sv
module lpstop_wake #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_pulse,
  input  logic [MASK_W-1:0] mask,
  input  logic [MASK_W-1:0] irq_level,
  output logic              stop_req
);

  localparam logic [MASK_W-1:0] TOP_LVL = '1;

  logic wake;
  logic stop_q, stop_d;

  always_comb begin
    wake   = (irq_level > mask) || (irq_level == TOP_LVL);
    stop_d = (stop_q || set_pulse) && !wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d;
  end

  assign stop_req = stop_q;

  // R6: request only rises right after the acknowledge cycle
  a_r6_rise_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(set_pulse));

  // R7 / R8: pending wake drops the request on the next edge
  a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && ((irq_level > mask) || (irq_level == TOP_LVL))) |=> !stop_req);

endmodule

// File: rtl/lpstop_bcast_ctl.sv
module lpstop_bcast_ctl #(
  parameter int               ADDR_W     = 24,
  parameter int               FC_W       = 3,
  parameter int               DATA_W     = 16,
  parameter int               MASK_W     = 3,
  parameter int               MASK_LSB   = 8,
  parameter logic [ADDR_W-1:0] STOP_ADDR  = 24'h03FFFE,
  parameter logic [FC_W-1:0]  CPU_FC     = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FC_W-1:0]   bus_fc,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_as,
  input  logic              bus_wr,
  input  logic              bus_owned,
  input  logic              bus_err,
  input  logic [MASK_W-1:0] irq_level,
  output logic              cyc_ack,
  output logic              ext_show_en,
  output logic [MASK_W-1:0] stop_mask,
  output logic              stop_req
);

  logic rst_sync_n;
  logic hit;
  logic done_pulse;

  lpstop_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpstop_decode #(
    .ADDR_W     (ADDR_W),
    .FC_W       (FC_W),
    .MATCH_ADDR (STOP_ADDR),
    .MATCH_FC   (CPU_FC)
  ) u_dec (
    .bus_as   (bus_as),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_fc   (bus_fc),
    .hit      (hit)
  );

  lpstop_seq #(
    .DATA_W   (DATA_W),
    .MASK_W   (MASK_W),
    .MASK_LSB (MASK_LSB)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit         (hit),
    .bus_as      (bus_as),
    .bus_owned   (bus_owned),
    .bus_err     (bus_err),
    .bus_wdata   (bus_wdata),
    .cyc_ack     (cyc_ack),
    .ext_show_en (ext_show_en),
    .stop_mask   (stop_mask),
    .done_pulse  (done_pulse)
  );

  lpstop_wake #(.MASK_W(MASK_W)) u_wake (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_pulse (done_pulse),
    .mask      (stop_mask),
    .irq_level (irq_level),
    .stop_req  (stop_req)
  );

  // R1: no acknowledge without a decoded broadcast on the previous edge
  a_r1_ack_needs_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(cyc_ack) |-> $past(hit));

endmodule

// File: tb/tb_lpstop_bcast_ctl.sv
module tb_lpstop_bcast_ctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [15:0] bus_wdata;
  logic        bus_as, bus_wr, bus_owned, bus_err;
  logic [2:0]  irq_level;
  logic        cyc_ack, ext_show_en, stop_req;
  logic [2:0]  stop_mask;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       ack;
    logic       show;
    logic [2:0] mask;
    logic       stop;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  localparam logic [23:0] STOP_A = 24'h03FFFE;

  always #5 clk = ~clk;

  lpstop_bcast_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_wdata(bus_wdata), .bus_as(bus_as), .bus_wr(bus_wr),
    .bus_owned(bus_owned), .bus_err(bus_err), .irq_level(irq_level),
    .cyc_ack(cyc_ack), .ext_show_en(ext_show_en), .stop_mask(stop_mask),
    .stop_req(stop_req)
  );

  function automatic void compare(exp_t e, string tag);
    vectors++;
    if (cyc_ack !== e.ack || ext_show_en !== e.show ||
        stop_mask !== e.mask || stop_req !== e.stop) begin
      miscompares++;
      $display("FAIL %s: got ack=%b show=%b mask=%0d stop=%b, expected ack=%b show=%b mask=%0d stop=%b",
               tag, cyc_ack, ext_show_en, stop_mask, stop_req,
               e.ack, e.show, e.mask, e.stop);
    end
  endfunction

  // monitor: pops one expectation per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_set(logic as, logic wr, logic [2:0] fc, logic [23:0] a,
                         logic [15:0] d);
    bus_as = as; bus_wr = wr; bus_fc = fc; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_idle();
    bus_set(1'b0, 1'b0, 3'b000, 24'h0, 16'h0);
  endtask

  // driver: inputs are already set; push expectation, advance one clock
  task automatic step(logic ack, logic show, logic [2:0] mask, logic stop,
                      string tag);
    exp_t e;
    e.ack = ack; e.show = show; e.mask = mask; e.stop = stop;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    exp_t r;
    rst_n = 1'b0;
    bus_idle();
    bus_owned = 1'b1; bus_err = 1'b0; irq_level = 3'd0;
    #23;
    r = '0;
    compare(r, "R9 reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(1'b0, 1'b0, 3'd0, 1'b0, "R9 after release");

    // owned bus, mask 3
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h0300);
    step(1'b1, 1'b1, 3'd3, 1'b0, "R3 R5 R2 ack owned");
    bus_idle();
    step(1'b0, 1'b0, 3'd3, 1'b1, "R6 stop rises");
    irq_level = 3'd3;
    step(1'b0, 1'b0, 3'd3, 1'b1, "R6 equal level holds");
    irq_level = 3'd4;
    step(1'b0, 1'b0, 3'd3, 1'b0, "R7 wake above mask");
    irq_level = 3'd0;

    // bus error, not owned, junk in other bits, strobe held
    bus_owned = 1'b0; bus_err = 1'b1;
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h5500);
    step(1'b1, 1'b0, 3'd5, 1'b0, "R4 R5 R2 berr not owned");
    step(1'b0, 1'b0, 3'd5, 1'b1, "R3 held strobe no reack");
    step(1'b0, 1'b0, 3'd5, 1'b1, "R3 held strobe again");
    bus_idle(); bus_err = 1'b0; bus_owned = 1'b1;
    step(1'b0, 1'b0, 3'd5, 1'b1, "R6 after drain");
    irq_level = 3'd5;
    step(1'b0, 1'b0, 3'd5, 1'b1, "R6 equal holds");
    irq_level = 3'd6;
    step(1'b0, 1'b0, 3'd5, 1'b0, "R7 wake level 6");
    irq_level = 3'd0;

    // mask 7, level 7 wake
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h0700);
    step(1'b1, 1'b1, 3'd7, 1'b0, "R2 mask 7");
    bus_idle(); irq_level = 3'd6;
    step(1'b0, 1'b0, 3'd7, 1'b1, "R6 level 6 under mask 7");
    irq_level = 3'd7;
    step(1'b0, 1'b0, 3'd7, 1'b0, "R8 level 7 wakes");
    irq_level = 3'd0;

    // non-matching cycles
    bus_set(1'b1, 1'b1, 3'b101, STOP_A, 16'h0200);
    step(1'b0, 1'b0, 3'd7, 1'b0, "R1 wrong fc");
    bus_set(1'b1, 1'b0, 3'b111, STOP_A, 16'h0200);
    step(1'b0, 1'b0, 3'd7, 1'b0, "R1 read");
    bus_set(1'b1, 1'b1, 3'b111, 24'h03FFFC, 16'h0200);
    step(1'b0, 1'b0, 3'd7, 1'b0, "R1 wrong addr");
    bus_set(1'b0, 1'b1, 3'b111, STOP_A, 16'h0200);
    step(1'b0, 1'b0, 3'd7, 1'b0, "R1 no strobe");
    bus_idle();
    step(1'b0, 1'b0, 3'd7, 1'b0, "R1 idle after");

    // wake already pending at completion
    irq_level = 3'd5;
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h0200);
    step(1'b1, 1'b1, 3'd2, 1'b0, "R10 ack with wake pending");
    bus_idle();
    step(1'b0, 1'b0, 3'd2, 1'b0, "R10 no rise");
    step(1'b0, 1'b0, 3'd2, 1'b0, "R10 stays low");
    irq_level = 3'd0;

    // second broadcast while stopped
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h0100);
    step(1'b1, 1'b1, 3'd1, 1'b0, "R2 mask 1");
    bus_idle();
    step(1'b0, 1'b0, 3'd1, 1'b1, "R6 stopped");
    bus_set(1'b1, 1'b1, 3'b111, STOP_A, 16'h0600);
    step(1'b1, 1'b1, 3'd6, 1'b1, "R2 relatch while stopped");
    bus_idle(); irq_level = 3'd6;
    step(1'b0, 1'b0, 3'd6, 1'b1, "R6 holds at 6");
    irq_level = 3'd7;
    step(1'b0, 1'b0, 3'd6, 1'b0, "R8 level 7");
    irq_level = 3'd0;

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule